// File: doc/BRIEF.md
# Event-Stepped I2C Master

This block is an I2C bus master that software drives one bus event at a time through a small register window. An event is a START, a repeated START, one address or data byte with its acknowledge slot, or a STOP. When an event other than STOP finishes, the block sets a completion flag, raises `irq` and posts a status code. It then parks the bus with SCL pulled low until software writes the flag back to zero. The code tells software exactly what happened on the wire, so the driver can decide the next step: another byte, a repeated START to turn the bus around, or a STOP.

Both bus lines are open-drain. The block only ever pulls a line low, and it reads SDA back from the pad to sample data and acknowledge bits. SCL timing comes from a two-stage divider: a power-of-two pre-divide followed by a linear factor. A soft-reset register returns the controller to its idle state without touching the divider setting. The block is a master only.

Top module: `i2cm_top`

## Requirements
- R1: Writing control with bus-enable (bit 4) and START request (bit 3) set makes the block send a START. The START request bit reads 1 until the condition has been sent, then clears itself.
- R2: After each completed START, repeated START or byte, the flag (control bit 1) and `irq` go to 1 and SCL is held low. No further bus event begins while the flag is 1. Writing 0 to bit 1 clears the flag. Writing 1 to bit 1 changes nothing.
- R3: A byte written to the data register (address 1) is shifted out MSB first when the flag is cleared. A received byte is readable from the same register once its event has completed.
- R4: Status (address 2) codes are: START 0x10, repeated START 0x18, address+write ACK 0x20 and NAK 0x28, data sent ACK 0x30 and NAK 0x38, address+read ACK 0x40 and NAK 0x48, data received with ACK 0x50 and with NAK 0x58. A START issued while the bus is already held reports 0x18.
- R5: Status reads 0xE0 exactly when the bus is free, which is after reset, after a STOP and after a soft reset.
- R6: On a read, the acknowledge-enable bit (control bit 0) picks what the master returns for each received byte: a set bit gives ACK and status 0x50, a clear bit gives NAK and status 0x58.
- R7: The first byte after a START or repeated START is the address byte, whose bit 0 sets the direction (0 write, 1 read). The acknowledge the target returns selects 0x20/0x28 or 0x40/0x48.
- R8: With the bus held, the STOP request (control bit 2) sends a STOP. Status returns to 0xE0, both lines are released and the flag is not set.
- R9: The clock register (address 3) holds N in bits 2:0 and M in bits 6:3. One quarter of an SCL bit lasts (M+1)·2^N input clocks, and SCL stays released for two quarters of each bit.
- R10: Writing 1 to bit 0 of the soft-reset register (address 4) clears the control and status state. The register reads 1 while the reset runs and 0 once it has finished.
- R11: While bus-enable is 0, a START request is not accepted: the bit reads 0 and both lines stay released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Event-complete flag |
| sda_i | input | 1 | SDA level sampled from the pad |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A phase or bit counter that slips usually shows at the ports within one byte. The status code comes out wrong, SDA changes while SCL is released, or the acknowledge slot falls on the wrong clock, and the target model then loses sync. A stale direction or address-pending bit gives the wrong code class (write versus read, address versus data) on the very next event. A flag that does not gate the engine shows up as SCL released, or a new event beginning, while `irq` is still high. The bench checks for this over long waits. The divider setting is checked by counting the cycles of one SCL high phase.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [7:0] {
    ST_START   = 8'h10,
    ST_RSTART  = 8'h18,
    ST_AW_ACK  = 8'h20,
    ST_AW_NAK  = 8'h28,
    ST_TXD_ACK = 8'h30,
    ST_TXD_NAK = 8'h38,
    ST_AR_ACK  = 8'h40,
    ST_AR_NAK  = 8'h48,
    ST_RXD_ACK = 8'h50,
    ST_RXD_NAK = 8'h58,
    ST_IDLE    = 8'hE0
  } stat_e;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_BYTE  = 2'd1,
    CMD_STOP  = 2'd2
  } cmd_e;

  localparam int CB_ACK   = 0;
  localparam int CB_FLAG  = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_START = 3;
  localparam int CB_BUSEN = 4;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_DATA = 3'd1;
  localparam logic [2:0] RA_STAT = 3'd2;
  localparam logic [2:0] RA_CLK  = 3'd3;
  localparam logic [2:0] RA_SRST = 3'd4;

  // clocks in one quarter of an SCL bit
  function automatic int unsigned quarter_len(int unsigned m, int unsigned n);
    return (m + 1) << n;
  endfunction

  function automatic stat_e addr_status(logic rd, logic acked);
    if (rd) return acked ? ST_AR_ACK : ST_AR_NAK;
    return acked ? ST_AW_ACK : ST_AW_NAK;
  endfunction

  function automatic stat_e data_status(logic rd, logic acked);
    if (rd) return acked ? ST_RXD_ACK : ST_RXD_NAK;
    return acked ? ST_TXD_ACK : ST_TXD_NAK;
  endfunction

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int Q_W = 12
) (
  input  logic           clk,
  input  logic           rst_i,
  input  logic           restart,
  input  logic [Q_W-1:0] qlen,
  output logic           tick
);
  logic [Q_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst_i) cnt <= '0;
    else if (restart || cnt == '0) cnt <= qlen - Q_W'(1);
    else cnt <= cnt - Q_W'(1);
  end

  assign tick = (cnt == '0) && !restart;
endmodule

// File: rtl/i2cm_softrst.sv
module i2cm_softrst #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (kick) cnt <= CW'(RST_CYCLES);
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int Q_W = 12
) (
  input  logic           clk,
  input  logic           rst_i,
  input  logic           go,
  input  cmd_e           cmd,
  input  logic [7:0]     tx_byte,
  input  logic           ack_en,
  input  logic [Q_W-1:0] qlen,
  input  logic           sda_i,
  output logic           busy,
  output logic           held,
  output logic           done,
  output stat_e          ev_status,
  output logic [7:0]     rx_byte,
  output logic           scl_oe,
  output logic           sda_oe
);
  typedef enum logic [2:0] {E_IDLE, E_HOLD, E_START, E_BYTE, E_STOP} est_e;

  est_e       st;
  logic [1:0] ph;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       rbit, ack_q, dir_q, addr_next, from_hold;
  logic       tick, last_q, ack_slot, tx_mode;

  i2cm_tick #(.Q_W(Q_W)) u_tick (
    .clk(clk), .rst_i(rst_i), .restart(go), .qlen(qlen), .tick(tick)
  );

  assign busy     = (st == E_START) || (st == E_BYTE) || (st == E_STOP);
  assign held     = (st == E_HOLD);
  assign ack_slot = (bitcnt == 4'd8);
  assign tx_mode  = addr_next || !dir_q;
  assign last_q   = tick && (ph == 2'd3);
  assign done     = last_q && ((st == E_START) || (st == E_STOP) ||
                               (st == E_BYTE && ack_slot));
  assign rx_byte  = shreg;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      st <= E_IDLE; ph <= '0; bitcnt <= '0; shreg <= '0;
      rbit <= 1'b1; ack_q <= 1'b0; dir_q <= 1'b0;
      addr_next <= 1'b0; from_hold <= 1'b0;
    end else if (go) begin
      ph <= '0;
      bitcnt <= '0;
      shreg <= tx_byte;
      ack_q <= ack_en;
      from_hold <= (st == E_HOLD);
      case (cmd)
        CMD_START: st <= E_START;
        CMD_STOP:  st <= E_STOP;
        default: begin
          st <= E_BYTE;
          if (addr_next) dir_q <= tx_byte[0];
        end
      endcase
    end else if (tick && busy) begin
      ph <= ph + 2'd1;
      if (ph == 2'd1) rbit <= sda_i;
      if (ph == 2'd3) begin
        case (st)
          E_START: begin st <= E_HOLD; addr_next <= 1'b1; end
          E_STOP:  begin st <= E_IDLE; addr_next <= 1'b0; end
          default: begin
            if (ack_slot) begin
              st <= E_HOLD;
              addr_next <= 1'b0;
            end else begin
              bitcnt <= bitcnt + 4'd1;
              shreg <= {shreg[6:0], rbit};
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    ev_status = ST_IDLE;
    case (st)
      E_START: ev_status = from_hold ? ST_RSTART : ST_START;
      E_BYTE: begin
        if (addr_next) ev_status = addr_status(dir_q, !rbit);
        else ev_status = data_status(dir_q, dir_q ? ack_q : !rbit);
      end
      default: ev_status = ST_IDLE;
    endcase
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      E_HOLD: scl_oe = 1'b1;
      E_START: begin
        scl_oe = (ph == 2'd0) ? from_hold : (ph == 2'd3);
        sda_oe = ph[1];
      end
      E_BYTE: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        if (ack_slot) sda_oe = !tx_mode && ack_q;
        else sda_oe = tx_mode && !shreg[7];
      end
      E_STOP: begin
        scl_oe = (ph == 2'd0);
        sda_oe = !ph[1];
      end
      default: ;
    endcase
  end

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (rst_i)
    (st == E_BYTE && !scl_oe && $past(st == E_BYTE && !scl_oe)) |-> $stable(sda_oe)); // R3

  AST_ACK_SLOT_DRIVE: assert property (@(posedge clk) disable iff (rst_i)
    (st == E_BYTE && ack_slot && !addr_next && dir_q && !scl_oe) |-> (sda_oe == ack_q)); // R6

endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
  import i2cm_pkg::*;
#(
  parameter int       N_W        = 3,
  parameter int       M_W        = 4,
  parameter int       RST_CYCLES = 4,
  parameter bit [7:0] CLK_RST    = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int CK_W = M_W + N_W;
  localparam int Q_W  = M_W + (1 << N_W);

  logic            soft_busy, rst_i;
  logic            bus_en, start_req, stop_req, flag, ack_en;
  logic [7:0]      data_r;
  stat_e           status_r;
  logic [CK_W-1:0] clk_r;
  logic [Q_W-1:0]  qlen;
  logic            wr_ctrl, wr_data, wr_clk, wr_srst;
  logic            can_go, eng_go, eng_busy, eng_held, eng_done;
  cmd_e            eng_cmd;
  stat_e           ev_status;
  logic [7:0]      rx_byte;
  logic            ev_rx;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_data = reg_wr && (reg_addr == RA_DATA);
  assign wr_clk  = reg_wr && (reg_addr == RA_CLK);
  assign wr_srst = reg_wr && (reg_addr == RA_SRST) && reg_wdata[0];

  i2cm_softrst #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk(clk), .rst_n(rst_n), .kick(wr_srst), .busy(soft_busy)
  );

  assign rst_i = !rst_n || soft_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) clk_r <= CLK_RST[CK_W-1:0];
    else if (wr_clk) clk_r <= reg_wdata[CK_W-1:0];
  end

  assign qlen = Q_W'(quarter_len(int'(clk_r[CK_W-1:N_W]), int'(clk_r[N_W-1:0])));

  // launch decision from registered control state only
  assign can_go = bus_en && !flag && !eng_busy;
  always_comb begin
    eng_go  = 1'b0;
    eng_cmd = CMD_BYTE;
    if (can_go) begin
      if (start_req) begin
        eng_go = 1'b1; eng_cmd = CMD_START;
      end else if (stop_req && eng_held) begin
        eng_go = 1'b1; eng_cmd = CMD_STOP;
      end else if (eng_held) begin
        eng_go = 1'b1; eng_cmd = CMD_BYTE;
      end
    end
  end

  i2cm_engine #(.Q_W(Q_W)) u_eng (
    .clk(clk), .rst_i(rst_i), .go(eng_go), .cmd(eng_cmd),
    .tx_byte(data_r), .ack_en(ack_en), .qlen(qlen), .sda_i(sda_i),
    .busy(eng_busy), .held(eng_held), .done(eng_done),
    .ev_status(ev_status), .rx_byte(rx_byte),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign ev_rx = (ev_status == ST_RXD_ACK) || (ev_status == ST_RXD_NAK);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      bus_en <= 1'b0; start_req <= 1'b0; stop_req <= 1'b0;
      flag <= 1'b0; ack_en <= 1'b0;
      data_r <= '0; status_r <= ST_IDLE;
    end else begin
      if (wr_ctrl) begin
        bus_en <= reg_wdata[CB_BUSEN];
        ack_en <= reg_wdata[CB_ACK];
        if (reg_wdata[CB_BUSEN] && reg_wdata[CB_START]) start_req <= 1'b1;
        if (reg_wdata[CB_BUSEN] && reg_wdata[CB_STOP])  stop_req  <= 1'b1;
        if (!reg_wdata[CB_FLAG]) flag <= 1'b0;
      end
      if (wr_data) data_r <= reg_wdata;
      if (stop_req && !start_req && !eng_busy && !eng_held) stop_req <= 1'b0;
      if (eng_done) begin
        status_r <= ev_status;
        if (ev_status != ST_IDLE) flag <= 1'b1;
        else stop_req <= 1'b0;
        if (ev_status == ST_START || ev_status == ST_RSTART) start_req <= 1'b0;
        if (ev_rx) data_r <= rx_byte;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {3'b000, bus_en, start_req, stop_req, flag, ack_en};
      RA_DATA: reg_rdata = data_r;
      RA_STAT: reg_rdata = status_r;
      RA_CLK:  reg_rdata = 8'(clk_r);
      RA_SRST: reg_rdata = {7'b0, soft_busy};
      default: reg_rdata = '0;
    endcase
  end

  assign irq = flag;

  AST_FLAG_PARKS_SCL: assert property (@(posedge clk) disable iff (rst_i)
    flag |-> scl_oe); // R2

  AST_FLAG_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (rst_i)
    (flag && eng_held) |=> eng_held); // R2

  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst_i)
    $fell(start_req) |-> (status_r == ST_START || status_r == ST_RSTART)); // R1

  AST_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (rst_i)
    (!eng_busy && !eng_held) |-> (status_r == ST_IDLE)); // R5

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst_i)
    (!bus_en && !start_req && !(wr_ctrl && reg_wdata[CB_BUSEN])) |=> !start_req); // R11

endmodule

// File: tb/i2cm_top_test.sv
module i2cm_top_test;
  localparam logic [7:0] BEN = 8'h10, STA = 8'h08, STO = 8'h04, FLG = 8'h02, ACK = 8'h01;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_oe, sda_oe, sda_line, scl_line;
  logic pull = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | pull);

  i2cm_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // ---------------- target model ----------------
  logic scl_p = 1'b1, sda_p = 1'b1, armed = 1'b0, first = 1'b0, rd = 1'b0, acked = 1'b0, mack = 1'b0;
  logic [3:0] bitpos = '0;
  logic [7:0] sh = '0, txb = '0, rxlast = '0;
  int rd_idx = 0;

  function automatic logic [7:0] tgt_byte(int i);
    return (i == 0) ? 8'h96 : 8'h3C;
  endfunction

  always @(posedge clk) begin
    scl_p <= scl_line;
    sda_p <= sda_line;
    if (scl_line && scl_p && sda_p && !sda_line) begin
      armed <= 1'b0; bitpos <= '0; first <= 1'b1; rd <= 1'b0; pull <= 1'b0; acked <= 1'b0;
    end else if (scl_line && scl_p && !sda_p && sda_line) begin
      armed <= 1'b0; pull <= 1'b0;
    end else if (scl_line && !scl_p) begin
      if (rd && !first) begin
        if (bitpos == 4'd8) mack <= !sda_line;
      end else if (bitpos < 4'd8) sh <= {sh[6:0], sda_line};
    end else if (!scl_line && scl_p) begin
      if (!armed) armed <= 1'b1;
      else if (bitpos == 4'd7) begin
        bitpos <= 4'd8;
        if (rd && !first) pull <= 1'b0;
        else if (first) begin
          acked <= (sh[7:1] == SLV);
          rd <= sh[0];
          pull <= (sh[7:1] == SLV);
        end else begin
          rxlast <= sh;
          pull <= (sh != 8'hEE);
        end
      end else if (bitpos == 4'd8) begin
        bitpos <= '0;
        first <= 1'b0;
        if ((first && rd && acked) || (!first && rd && mack)) begin
          txb <= tgt_byte(rd_idx);
          pull <= ~tgt_byte(rd_idx)[7];
          rd_idx <= rd_idx + 1;
        end else pull <= 1'b0;
      end else begin
        bitpos <= bitpos + 4'd1;
        if (rd && !first) pull <= ~txb[3'(6 - bitpos)];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // driver: push expected code, wait for the event, push observed code
  task automatic expect_event(input logic [7:0] code, input string tag);
    logic [7:0] s;
    int n;
    exp_q.push_back(code);
    tag_q.push_back(tag);
    n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    rd_reg(3'd2, s);
    got_q.push_back(irq ? s : 8'hFF);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    s = 8'h00;
    while (s != 8'hE0 && n < 5000) begin rd_reg(3'd2, s); n++; end
    chk(s, 8'hE0, "R8 stop returns to idle code");
  endtask

  // monitor: compare as results arrive
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        total++;
        if (g !== e) begin
          bad++;
          $display("FAIL %s got=%0h exp=%0h", t, g, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int hi;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rd_reg(3'd0, v); chk(v, 8'h00, "R10 reset control value");
    rd_reg(3'd2, v); chk(v, 8'hE0, "R5 idle code after reset");
    chk({scl_oe, sda_oe}, 2'b00, "R5 lines released after reset");

    // R11: START without bus enable
    wr(3'd0, STA);
    rd_reg(3'd0, v); chk(v[3], 1'b0, "R11 start ignored without bus enable");
    repeat (30) @(negedge clk);
    chk({scl_oe, sda_oe, irq}, 3'b000, "R11 no bus activity while disabled");

    // write transfer
    wr(3'd0, BEN);
    wr(3'd0, BEN | STA);
    rd_reg(3'd0, v); chk(v[3], 1'b1, "R1 start bit pending before condition");
    expect_event(8'h10, "R1 start status");
    rd_reg(3'd0, v); chk(v[3], 1'b0, "R1 start bit self-cleared");
    chk(irq, 1'b1, "R2 flag raised after event");
    repeat (40) @(negedge clk);
    chk(scl_oe, 1'b1, "R2 scl parked low while flag set");
    wr(3'd0, BEN | FLG);
    repeat (40) @(negedge clk);
    rd_reg(3'd2, v); chk(v, 8'h10, "R2 writing 1 to flag starts nothing");
    chk({irq, scl_oe}, 2'b11, "R2 flag kept by writing 1");

    wr(3'd1, {SLV, 1'b0});
    wr(3'd0, BEN);
    expect_event(8'h20, "R7 address write acked");
    wr(3'd1, 8'h11);
    wr(3'd0, BEN);
    expect_event(8'h30, "R3 data sent and acked");
    chk(rxlast, 8'h11, "R3 target received byte");
    wr(3'd1, 8'hEE);
    wr(3'd0, BEN);
    expect_event(8'h38, "R4 data sent and nacked");

    // turn around with repeated START, then read two bytes
    wr(3'd0, BEN | STA);
    expect_event(8'h18, "R4 repeated start status");
    wr(3'd1, {SLV, 1'b1});
    wr(3'd0, BEN);
    expect_event(8'h40, "R7 address read acked");
    wr(3'd0, BEN | ACK);
    expect_event(8'h50, "R6 byte received with ack");
    rd_reg(3'd1, v); chk(v, 8'h96, "R3 first received byte");
    wr(3'd0, BEN);
    expect_event(8'h58, "R6 byte received with nak");
    rd_reg(3'd1, v); chk(v, 8'h3C, "R3 second received byte");

    wr(3'd0, BEN | STO);
    wait_idle();
    repeat (4) @(negedge clk);
    chk({irq, scl_oe, sda_oe}, 3'b000, "R8 lines released, flag clear after stop");

    // wrong address
    wr(3'd0, BEN | STA);
    expect_event(8'h10, "R1 start from idle");
    wr(3'd1, 8'h30);
    wr(3'd0, BEN);
    expect_event(8'h28, "R7 address write nacked");
    wr(3'd0, BEN | STO);
    wait_idle();

    // divider: M=2, N=1 -> quarter of 6 clocks, high phase 12
    wr(3'd0, BEN | STA);
    expect_event(8'h10, "R1 start before divider check");
    wr(3'd1, {SLV, 1'b0});
    wr(3'd0, BEN);
    expect_event(8'h20, "R7 address before divider check");
    wr(3'd3, {1'b0, 4'd2, 3'd1});
    wr(3'd1, 8'h55);
    wr(3'd0, BEN);
    hi = 0;
    do @(negedge clk); while (scl_oe && hi++ < 1000);
    hi = 0;
    while (!scl_oe && hi < 1000) begin hi++; @(negedge clk); end
    chk(hi, 2 * (2 + 1) * (1 << 1), "R9 scl high length from divider");
    expect_event(8'h30, "R9 byte at slower rate acked");
    chk(rxlast, 8'h55, "R9 byte at slower rate intact");

    // soft reset while bus held
    wr(3'd4, 8'h01);
    rd_reg(3'd4, v); chk(v, 8'h01, "R10 soft reset reads busy");
    repeat (12) @(negedge clk);
    rd_reg(3'd4, v); chk(v, 8'h00, "R10 soft reset finished");
    rd_reg(3'd0, v); chk(v, 8'h00, "R10 control cleared");
    rd_reg(3'd2, v); chk(v, 8'hE0, "R5 idle code after soft reset");
    chk({irq, scl_oe, sda_oe}, 3'b000, "R10 bus released by soft reset");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule